// File: doc/BRIEF.md
# I2C Bus Busy Monitor

This block watches the SCL and SDA lines of an I2C bus without driving them and reports whether the bus is occupied. Activity from every master counts, including the local one. A start condition is SDA falling while SCL is high, and it marks the bus as taken. A stop condition is SDA rising while SCL is high, and it marks the bus as released. Each detected condition also gives a single-cycle pulse, so neighbouring logic can follow the bus framing.

A master can abandon a transfer without sending a stop, for example when it is reset. The monitor covers this case with an idle timer. When both lines stay high for a configured time, the bus is declared free whatever state came before. The time is set in seconds and turned into clock cycles from the system clock frequency. Both raw lines pass through a two-flop synchroniser before any edge is examined.

Top module: `i2c_bus_monitor`

## Requirements
- R1: While reset is asserted and in the first cycle after it, busy_o reads 0 and start_o and stop_o read 0.
- R2: start_o pulses for exactly one cycle when a synchronised sample shows SDA going 1 to 0 and SCL reads 1 in both that sample and the previous one. The pulse appears two clock edges after the input sample that shows the SDA fall.
- R3: busy_o is 1 in the cycle after every start_o pulse, and busy_o only rises in the cycle after a start_o pulse.
- R4: stop_o pulses for exactly one cycle when SDA goes 0 to 1 with SCL at 1 in both samples, and busy_o is 0 in the cycle after the pulse.
- R5: SDA edges that occur while SCL is low, or in the same sample where SCL changes, produce no pulse and leave busy_o unchanged.
- R6: If both lines read 1 for TIMEOUT consecutive synchronised samples, busy_o drops to 0 without any stop condition. busy_o reads 0 at the edge TIMEOUT+2 edges after the first input sample with both lines high.
- R7: Any sample with SCL or SDA low restarts the idle count from zero. The count saturates at TIMEOUT.
- R8: TIMEOUT equals CLK_FREQ_HZ times FREE_TIMEOUT_S, rounded to the nearest cycle and at least 1. With the defaults of 100 MHz and 1 µs this is 100.
- R9: start_o and stop_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| busy_o | output | 1 | Bus is taken by some master |
| start_o | output | 1 | Single-cycle start condition detect |
| stop_o | output | 1 | Single-cycle stop condition detect |

## Verification
The bound checker watches five things on every cycle:
- that start and stop never coincide and never repeat on back-to-back cycles;
- that busy rises only after a start;
- that busy falls after a stop or after the idle limit is reached;
- that a low line clears the idle count;
- that the count never passes its limit.

The exact latency from a line change to a pulse, and the precise cycle at which an abandoned transfer is released, can only be shown by the bench. The same holds for a timeout that restarts after a brief SCL dip and for simultaneous SCL and SDA changes. The bench runs these scenarios against its sample-history model.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;

  // Convert a time in seconds to a whole number of clock cycles (at least 1).
  function automatic int idle_cycles(input real clk_hz, input real seconds);
    int n;
    n = $rtoi(clk_hz * seconds + 0.5);
    if (n < 1) n = 1;
    return n;
  endfunction

  function automatic int count_width(input int limit);
    return (limit < 1) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/i2c_mon_sync.sv
module i2c_mon_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [LINES-1:0] d_i,
  output logic [LINES-1:0] q_o
);

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i) begin
      if (rst_i) chain_q <= '1;
      else       chain_q <= {chain_q[STAGES-2:0], d_i[l]};
    end
    assign q_o[l] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/i2c_mon_cond_detect.sv
module i2c_mon_cond_detect (
  input  logic clk_i,
  input  logic rst_i,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic start_o,
  output logic stop_o
);

  logic scl_prev_q;
  logic sda_prev_q;
  logic scl_steady_high;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_prev_q <= scl_s_i;
      sda_prev_q <= sda_s_i;
    end
  end

  assign scl_steady_high = scl_s_i & scl_prev_q;
  assign start_o = scl_steady_high &  sda_prev_q & ~sda_s_i;
  assign stop_o  = scl_steady_high & ~sda_prev_q &  sda_s_i;

endmodule

// File: rtl/i2c_mon_idle_timer.sv
module i2c_mon_idle_timer #(
  parameter int LIMIT = 100,
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             idle_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expired_o
);

  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || !idle_i)    cnt_q <= '0;
    else if (cnt_q != LIMIT_V) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o     = cnt_q;
  assign expired_o = (cnt_q == LIMIT_V);

endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor #(
  parameter real CLK_FREQ_HZ    = 100.0e6,
  parameter real FREE_TIMEOUT_S = 1.0e-6
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic busy_o,
  output logic start_o,
  output logic stop_o
);
  import i2c_mon_pkg::*;

  localparam int TIMEOUT_CYCLES = idle_cycles(CLK_FREQ_HZ, FREE_TIMEOUT_S);
  localparam int CNT_W          = count_width(TIMEOUT_CYCLES);

  logic [1:0]       lines_s;
  logic             scl_s;
  logic             sda_s;
  logic             idle_expired;
  logic [CNT_W-1:0] idle_cnt;
  logic             busy_q;

  i2c_mon_sync #(.LINES(2), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   ({scl_i, sda_i}),
    .q_o   (lines_s)
  );
  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  i2c_mon_cond_detect u_detect (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .scl_s_i (scl_s),
    .sda_s_i (sda_s),
    .start_o (start_o),
    .stop_o  (stop_o)
  );

  i2c_mon_idle_timer #(.LIMIT(TIMEOUT_CYCLES), .CNT_W(CNT_W)) u_idle (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .idle_i    (scl_s & sda_s),
    .cnt_o     (idle_cnt),
    .expired_o (idle_expired)
  );

  // A start wins; a stop or an expired idle window releases the bus.
  always_ff @(posedge clk_i) begin
    if (rst_i)                       busy_q <= 1'b0;
    else if (start_o)                busy_q <= 1'b1;
    else if (stop_o || idle_expired) busy_q <= 1'b0;
  end

  assign busy_o = busy_q;

endmodule

// File: rtl/i2c_bus_monitor_checker.sv
module i2c_bus_monitor_checker #(
  parameter int LIMIT = 100,
  parameter int CNT_W = 7
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             scl_s,
  input logic             sda_s,
  input logic             busy_o,
  input logic             start_o,
  input logic             stop_o,
  input logic             idle_expired,
  input logic [CNT_W-1:0] idle_cnt
);

  assert_reset_free_R1: assert property (@(posedge clk_i)
    rst_i |=> (!busy_o && !start_o && !stop_o));

  assert_start_single_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    start_o |=> !start_o);

  assert_start_busy_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    start_o |=> busy_o);

  assert_busy_rise_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(busy_o) |-> $past(start_o));

  assert_stop_free_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    stop_o |=> (!busy_o && !stop_o));

  assert_idle_free_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (idle_expired && !start_o) |=> !busy_o);

  assert_low_clears_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    !(scl_s && sda_s) |=> (idle_cnt == '0));

  assert_count_cap_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    idle_cnt <= CNT_W'(LIMIT));

  assert_exclusive_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    !(start_o && stop_o));

endmodule

bind i2c_bus_monitor i2c_bus_monitor_checker #(
  .LIMIT(TIMEOUT_CYCLES),
  .CNT_W(CNT_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_i        (rst_i),
  .scl_s        (scl_s),
  .sda_s        (sda_s),
  .busy_o       (busy_o),
  .start_o      (start_o),
  .stop_o       (stop_o),
  .idle_expired (idle_expired),
  .idle_cnt     (idle_cnt)
);

// File: tb/i2c_bus_monitor_bench.sv
`timescale 1ns/1ps
module i2c_bus_monitor_bench;

  // Timeout restated as 1000 ns over a 10 ns period (R8).
  localparam int TMO = 1000 / 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda = 1'b1;
  logic busy, start_p, stop_p;

  int tests = 0;
  int fails = 0;
  int n_start = 0;
  int n_stop = 0;

  always #5 clk = ~clk;

  i2c_bus_monitor u_i2c_bus_monitor (
    .clk_i(clk), .rst_i(rst), .scl_i(scl), .sda_i(sda),
    .busy_o(busy), .start_o(start_p), .stop_o(stop_p)
  );

  // Reference model: history of input samples, newest first.
  bit hs[4];
  bit hd[4];
  int m_cnt = 0;
  bit m_busy = 0, m_start = 0, m_stop = 0;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) begin hs[i] = 1; hd[i] = 1; end
      m_cnt = 0; m_busy = 0; m_start = 0; m_stop = 0;
    end else begin
      if (m_start) m_busy = 1;
      else if (m_stop || m_cnt == TMO) m_busy = 0;
      for (int i = 3; i > 0; i--) begin hs[i] = hs[i-1]; hd[i] = hd[i-1]; end
      hs[0] = scl; hd[0] = sda;
      if (hs[2] && hd[2]) m_cnt = (m_cnt < TMO) ? m_cnt + 1 : TMO;
      else m_cnt = 0;
      m_start = hs[1] && hs[2] && hd[2] && !hd[1];
      m_stop  = hs[1] && hs[2] && !hd[2] && hd[1];
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Per-cycle compare plus pulse counting.
  always @(negedge clk) begin
    if (!rst) begin
      check("R3/R4/R6", "busy vs model", busy, m_busy);
      check("R2", "start vs model", start_p, m_start);
      check("R4", "stop vs model", stop_p, m_stop);
      check("R9", "pulse exclusive", start_p & stop_p, 0);
      if (start_p) n_start++;
      if (stop_p) n_stop++;
    end
  end

  task automatic drive(input bit c, input bit d, input int hold);
    @(negedge clk);
    scl = c; sda = d;
    repeat (hold) @(negedge clk);
  endtask

  // Drives lines and returns negedge index at which busy first reads 0.
  task automatic time_release(input bit c, input bit d, output int j);
    @(negedge clk);
    scl = c; sda = d;
    j = 0;
    forever begin
      @(negedge clk);
      if (!busy || j > 4 * TMO) break;
      j++;
    end
  endtask

  int s0, p0, rel;

  initial begin
    repeat (5) @(negedge clk);
    check("R1", "busy in reset", busy, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "busy after reset", busy, 0);
    check("R1", "start after reset", start_p, 0);
    check("R1", "stop after reset", stop_p, 0);
    repeat (5) @(negedge clk);

    // Start condition: pulse lands two edges after the sample.
    s0 = n_start;
    @(negedge clk); sda = 0;
    @(negedge clk); check("R2", "start not yet", start_p, 0);
    @(negedge clk); check("R2", "start pulse latency", start_p, 1);
    @(negedge clk); check("R2", "start single cycle", start_p, 0);
    check("R3", "busy after start", busy, 1);

    // Data bits: SDA toggles only while SCL low.
    s0 = n_start; p0 = n_stop;
    for (int b = 0; b < 4; b++) begin
      drive(0, 0, 2);
      drive(0, b[0], 2);
      drive(1, b[0], 3);
    end
    drive(0, 1, 2);
    drive(0, 0, 2);
    drive(0, 1, 2);
    drive(0, 0, 3);
    check("R5", "no start during data", n_start - s0, 0);
    check("R5", "no stop during data", n_stop - p0, 0);
    check("R5", "busy held during data", busy, 1);

    // Stop condition.
    drive(1, 0, 3);
    p0 = n_stop;
    drive(1, 1, 4);
    check("R4", "stop count", n_stop - p0, 1);
    check("R4", "busy after stop", busy, 0);

    // SDA activity with SCL low on a free bus.
    s0 = n_start;
    drive(0, 1, 2); drive(0, 0, 2); drive(0, 1, 2);
    check("R5", "free bus stays free", busy, 0);
    check("R5", "no start scl low", n_start - s0, 0);
    drive(1, 1, 3);

    // Simultaneous SCL rise and SDA fall: not a start.
    drive(0, 1, 3);
    s0 = n_start;
    drive(1, 0, 4);
    check("R5", "simultaneous edge no start", n_start - s0, 0);
    check("R5", "simultaneous edge not busy", busy, 0);
    drive(1, 1, 4);

    // Abandoned transfer: both lines high together, no stop seen.
    drive(1, 0, 4);
    check("R3", "busy on second start", busy, 1);
    drive(0, 0, 3);
    p0 = n_stop;
    time_release(1, 1, rel);
    check("R6", "release latency", rel, TMO + 2);
    check("R6", "no stop on abandon", n_stop - p0, 0);
    check("R8", "timeout cycles", rel - 2, 100);

    // A brief SCL dip restarts the idle window.
    drive(1, 0, 4);
    drive(0, 0, 3);
    drive(1, 1, TMO / 2);
    drive(0, 1, 1);
    check("R7", "busy held over dip", busy, 1);
    time_release(1, 1, rel);
    check("R7", "window restarted", rel, TMO + 2);

    // Long idle: count saturates and bus stays free.
    repeat (3 * TMO) @(negedge clk);
    check("R7", "free after long idle", busy, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule